// File: doc/BRIEF.md
# Thermal Event Interrupt Controller

This block turns two already-filtered temperature comparator levels, a warning level and a shutdown level, into status bits, sticky interrupt flags and an active-low interrupt line for a host on a serial bus. Each flag is set on both the start and the end of its condition, so the host learns about both transitions. While a condition stays unchanged, no further interrupt is raised.

The host clears the flags by reading the interrupt status register inside a chip-select frame. The clear takes effect when chip-select rises at the end of that frame. A frame without a status read leaves every flag in place. The chip-select edge is found by registering chip-select in the system clock domain.

The block also drives the actions tied to each condition. During a warning it asks each current source to drop to its low wetting-current setting, unless that source's disable bit is set. During shutdown it asks for all source switches to open and forces the temperature bit of every serial response to 1. When shutdown ends it sends a one-cycle pulse that restarts switch polling from the first enabled channel.

Top module: `therm_irq_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `irq_n_o` is 1. All flags, status bits, requests and the pulse are 0.
- R2: When the warning level rises, `warn_flag_o` is 1 and `irq_n_o` is 0 on the cycle after the input change.
- R3: `warn_stat_o` equals (`warn_i` OR `shut_i`) delayed by one clock. `shut_stat_o` equals `shut_i` delayed by one clock.
- R4: Both flags are cleared at the clock edge where `cs_n_i` is first seen high, but only if `stat_rd_i` was high on some cycle while `cs_n_i` was low during that frame. A frame with no read leaves the flags unchanged.
- R5: Once a flag has been cleared, it stays 0 for as long as its condition level does not change.
- R6: When the warning level falls, `warn_flag_o` is set and `irq_n_o` goes to 0.
- R7: `wet_reduce_o[i]` is 1 exactly when the warning level (`warn_i` OR `shut_i`), delayed by one clock, is 1 and `cur_red_dis_i[i]` was 0. The disable bit has no effect on the flags or on `irq_n_o`.
- R8: When shutdown starts, `shut_flag_o`, `shut_stat_o`, `warn_stat_o` and `sw_open_o` are all 1 on the next cycle, and `irq_n_o` is 0.
- R9: `resp_temp_o` is 1 whenever shutdown is present (delayed by one clock) or either flag is pending. Otherwise it is 0.
- R10: When shutdown ends, `shut_flag_o` is set, `shut_stat_o` goes to 0, and `warn_stat_o` follows `warn_i`.
- R11: `poll_restart_o` is a one-cycle pulse, raised on the cycle after `shut_i` falls.
- R12: If a level change and a clear fall on the same edge, the flag for that change is 1 after the edge.
- R13: `irq_n_o` is 0 exactly when at least one flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| warn_i | input | 1 | Filtered warning comparator level |
| shut_i | input | 1 | Filtered shutdown comparator level |
| cs_n_i | input | 1 | Serial chip-select, active low |
| stat_rd_i | input | 1 | Strobe: the interrupt status register is being read |
| cur_red_dis_i | input | N_SRC | Per-source disable for the wetting-current reduction |
| irq_n_o | output | 1 | Interrupt to the host, active low |
| warn_flag_o | output | 1 | Sticky warning-transition flag |
| shut_flag_o | output | 1 | Sticky shutdown-transition flag |
| warn_stat_o | output | 1 | Warning level status |
| shut_stat_o | output | 1 | Shutdown level status |
| wet_reduce_o | output | N_SRC | Per-source request to reduce wetting current |
| sw_open_o | output | 1 | Request to open all current-source switches |
| resp_temp_o | output | 1 | Temperature bit for each serial response |
| poll_restart_o | output | 1 | One-cycle pulse to restart polling |

## Verification
The assertions assume the comparator levels arrive already free of glitches. They also assume `stat_rd_i` is only raised inside a chip-select frame, and that `shut_i` stays high for at least one clock whenever it rises. The stimulus holds every level for several cycles and raises the read strobe only while `cs_n_i` is low. The sweep steps through every pair of before/after level combinations, with all disable settings and three ways of ending a frame: with a read, without a read, and with a read whose chip-select rise falls on the same edge as a level change.

// File: rtl/therm_irq_pkg.sv
package therm_irq_pkg;
  localparam int COND_WARN = 0;
  localparam int COND_SHUT = 1;
  localparam int NUM_COND  = 2;
endpackage

// File: rtl/therm_lvl_track.sv
module therm_lvl_track (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic lvl_q,
  output logic chg_o,
  output logic fall_o
);
  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl_i;
  end

  assign chg_o  = lvl_i ^ lvl_q;
  assign fall_o = lvl_q & ~lvl_i;

  // R3: a detected change is followed by a flipped stored level
  p_chg_flips_r3: assert property (@(posedge clk) disable iff (rst)
    chg_o |=> (lvl_q != $past(lvl_q)));
endmodule

// File: rtl/therm_clr_ctrl.sv
module therm_clr_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic cs_n_i,
  input  logic rd_i,
  output logic clr_o
);
  logic cs_q;
  logic rd_seen_q;
  logic cs_rise;

  assign cs_rise = cs_n_i & ~cs_q;
  assign clr_o   = cs_rise & rd_seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q      <= 1'b1;
      rd_seen_q <= 1'b0;
    end else begin
      cs_q <= cs_n_i;
      if (cs_rise)               rd_seen_q <= 1'b0;
      else if (rd_i && !cs_n_i)  rd_seen_q <= 1'b1;
    end
  end

  // R4: a clear consumes the recorded read
  p_read_consumed_r4: assert property (@(posedge clk) disable iff (rst)
    clr_o |=> !rd_seen_q);
  // R4: a clear only happens while chip-select is high
  p_clr_on_high_r4: assert property (@(posedge clk) disable iff (rst)
    clr_o |-> cs_n_i);
endmodule

// File: rtl/therm_irq_ctrl.sv
module therm_irq_ctrl #(
  parameter int N_SRC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             warn_i,
  input  logic             shut_i,
  input  logic             cs_n_i,
  input  logic             stat_rd_i,
  input  logic [N_SRC-1:0] cur_red_dis_i,
  output logic             irq_n_o,
  output logic             warn_flag_o,
  output logic             shut_flag_o,
  output logic             warn_stat_o,
  output logic             shut_stat_o,
  output logic [N_SRC-1:0] wet_reduce_o,
  output logic             sw_open_o,
  output logic             resp_temp_o,
  output logic             poll_restart_o
);
  import therm_irq_pkg::*;

  logic [NUM_COND-1:0] lvl_in, lvl_q, chg, fall;
  logic [NUM_COND-1:0] flag_d, flag_q;
  logic                clr;

  assign lvl_in[COND_WARN] = warn_i | shut_i;
  assign lvl_in[COND_SHUT] = shut_i;

  therm_clr_ctrl u_clr (
    .clk    (clk),
    .rst    (rst),
    .cs_n_i (cs_n_i),
    .rd_i   (stat_rd_i),
    .clr_o  (clr)
  );

  for (genvar c = 0; c < NUM_COND; c++) begin : g_cond
    therm_lvl_track u_trk (
      .clk    (clk),
      .rst    (rst),
      .lvl_i  (lvl_in[c]),
      .lvl_q  (lvl_q[c]),
      .chg_o  (chg[c]),
      .fall_o (fall[c])
    );

    // a fresh transition wins over a clear on the same edge
    assign flag_d[c] = chg[c] | (flag_q[c] & ~clr);

    always_ff @(posedge clk) begin
      if (rst) flag_q[c] <= 1'b0;
      else     flag_q[c] <= flag_d[c];
    end
  end

  logic irq_n_q, sw_open_q, resp_q, poll_q;
  logic [N_SRC-1:0] wet_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_n_q   <= 1'b1;
      sw_open_q <= 1'b0;
      resp_q    <= 1'b0;
      poll_q    <= 1'b0;
    end else begin
      irq_n_q   <= ~|flag_d;
      sw_open_q <= shut_i;
      resp_q    <= shut_i | (|flag_d);
      poll_q    <= fall[COND_SHUT];
    end
  end

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) wet_q[s] <= 1'b0;
      else     wet_q[s] <= lvl_in[COND_WARN] & ~cur_red_dis_i[s];
    end
  end

  assign irq_n_o        = irq_n_q;
  assign warn_flag_o    = flag_q[COND_WARN];
  assign shut_flag_o    = flag_q[COND_SHUT];
  assign warn_stat_o    = lvl_q[COND_WARN];
  assign shut_stat_o    = lvl_q[COND_SHUT];
  assign wet_reduce_o   = wet_q;
  assign sw_open_o      = sw_open_q;
  assign resp_temp_o    = resp_q;
  assign poll_restart_o = poll_q;

  p_warn_entry_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(warn_stat_o) |-> (warn_flag_o && !irq_n_o));
  p_warn_exit_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(warn_stat_o) |-> (warn_flag_o && !irq_n_o));
  p_no_repeat_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(!warn_flag_o) && $stable(warn_stat_o)) |-> !warn_flag_o);
  p_shut_set_r8: assert property (@(posedge clk) disable iff (rst)
    shut_stat_o |-> (warn_stat_o && sw_open_o && resp_temp_o));
  p_shut_exit_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(shut_stat_o) |-> (shut_flag_o && poll_restart_o));
  p_poll_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    poll_restart_o |=> !poll_restart_o);
  p_wet_needs_warn_r7: assert property (@(posedge clk) disable iff (rst)
    (|wet_reduce_o) |-> warn_stat_o);
  p_irq_matches_r13: assert property (@(posedge clk) disable iff (rst)
    (irq_n_o == !(warn_flag_o || shut_flag_o)));
endmodule

// File: tb/therm_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module therm_irq_ctrl_tb_top;
  localparam int N_SRC = 2;

  logic clk = 1'b0;
  logic rst, warn_i, shut_i, cs_n_i, stat_rd_i;
  logic [N_SRC-1:0] cur_red_dis_i;
  logic irq_n_o, warn_flag_o, shut_flag_o, warn_stat_o, shut_stat_o;
  logic [N_SRC-1:0] wet_reduce_o;
  logic sw_open_o, resp_temp_o, poll_restart_o;

  always #2.5 clk = ~clk;

  therm_irq_ctrl #(.N_SRC(N_SRC)) dut_i (
    .clk(clk), .rst(rst), .warn_i(warn_i), .shut_i(shut_i),
    .cs_n_i(cs_n_i), .stat_rd_i(stat_rd_i), .cur_red_dis_i(cur_red_dis_i),
    .irq_n_o(irq_n_o), .warn_flag_o(warn_flag_o), .shut_flag_o(shut_flag_o),
    .warn_stat_o(warn_stat_o), .shut_stat_o(shut_stat_o),
    .wet_reduce_o(wet_reduce_o), .sw_open_o(sw_open_o),
    .resp_temp_o(resp_temp_o), .poll_restart_o(poll_restart_o)
  );

  int n_chk = 0;
  int n_err = 0;

  // reference state, derived from the requirements
  logic m_ws, m_ss, m_wf, m_sf, m_cs, m_rd, m_irq, m_open, m_resp, m_poll;
  logic [N_SRC-1:0] m_wet;

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R13 irq_n",            {3'b0, irq_n_o},        {3'b0, m_irq});
    chk("R2 R6 R12 warn_flag",  {3'b0, warn_flag_o},    {3'b0, m_wf});
    chk("R8 R10 shut_flag",     {3'b0, shut_flag_o},    {3'b0, m_sf});
    chk("R3 warn_stat",         {3'b0, warn_stat_o},    {3'b0, m_ws});
    chk("R8 R10 shut_stat",     {3'b0, shut_stat_o},    {3'b0, m_ss});
    chk("R7 wet_reduce",        {2'b0, wet_reduce_o},   {2'b0, m_wet});
    chk("R8 sw_open",           {3'b0, sw_open_o},      {3'b0, m_open});
    chk("R9 resp_temp",         {3'b0, resp_temp_o},    {3'b0, m_resp});
    chk("R11 poll_restart",     {3'b0, poll_restart_o}, {3'b0, m_poll});
  endtask

  task automatic model_reset();
    m_ws = 0; m_ss = 0; m_wf = 0; m_sf = 0; m_cs = 1; m_rd = 0;
    m_irq = 1; m_open = 0; m_resp = 0; m_poll = 0; m_wet = '0;
  endtask

  // drive one cycle, advance the model, then sample after the edge
  task automatic cyc(input logic w, input logic s, input logic cs, input logic rd,
                     input logic [N_SRC-1:0] dis);
    logic lw, ew, es, rise, clr, nwf, nsf;
    warn_i = w; shut_i = s; cs_n_i = cs; stat_rd_i = rd; cur_red_dis_i = dis;
    lw   = w | s;
    ew   = (lw != m_ws);
    es   = (s != m_ss);
    rise = cs & ~m_cs;
    clr  = rise & m_rd;
    nwf  = ew | (m_wf & ~clr);
    nsf  = es | (m_sf & ~clr);
    m_poll = m_ss & ~s;
    m_rd   = rise ? 1'b0 : (m_rd | (rd & ~cs));
    m_cs   = cs;
    m_wf = nwf; m_sf = nsf;
    m_ws = lw; m_ss = s;
    m_irq  = ~(nwf | nsf);
    m_resp = s | nwf | nsf;
    m_open = s;
    m_wet  = {N_SRC{lw}} & ~dis;
    @(posedge clk); #1;
    compare_all();
  endtask

  task automatic do_reset();
    rst = 1; warn_i = 0; shut_i = 0; cs_n_i = 1; stat_rd_i = 0; cur_red_dis_i = '0;
    repeat (2) @(posedge clk);
    #1; rst = 0;
    model_reset();
  endtask

  initial begin : watchdog
    #500000;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    do_reset();
    // R1: reset state
    chk("R1 irq_n idle", {3'b0, irq_n_o}, 4'h1);
    chk("R1 flags clear", {2'b0, warn_flag_o, shut_flag_o}, 4'h0);
    chk("R1 status clear", {1'b0, warn_stat_o, shut_stat_o, poll_restart_o}, 4'h0);

    // directed: R2 entry, R4 no-read keeps, R4 read clears, R5 no repeat
    cyc(1, 0, 1, 0, 2'b00);
    chk("R2 warn entry flag", {3'b0, warn_flag_o}, 4'h1);
    cyc(1, 0, 0, 0, 2'b00);
    cyc(1, 0, 1, 0, 2'b00);
    chk("R4 frame without read keeps flag", {3'b0, warn_flag_o}, 4'h1);
    cyc(1, 0, 0, 1, 2'b00);
    cyc(1, 0, 1, 0, 2'b00);
    chk("R4 read then rise clears", {3'b0, warn_flag_o}, 4'h0);
    for (int k = 0; k < 4; k++) begin
      cyc(1, 0, 1, 0, 2'b00);
      chk("R5 no repeat interrupt", {3'b0, irq_n_o}, 4'h1);
    end
    // R12: exit coincides with the clearing edge
    cyc(1, 0, 0, 1, 2'b00);
    cyc(0, 0, 1, 0, 2'b00);
    chk("R12 event beats clear", {3'b0, warn_flag_o}, 4'h1);

    // sweep: every before/after level pair, disable setting and frame ending
    for (int s0 = 0; s0 < 4; s0++)
      for (int s1 = 0; s1 < 4; s1++)
        for (int d = 0; d < 4; d++)
          for (int mode = 0; mode < 3; mode++) begin
            logic w0, h0, w1, h1;
            logic [N_SRC-1:0] dv;
            w0 = s0[0]; h0 = s0[1]; w1 = s1[0]; h1 = s1[1]; dv = d[N_SRC-1:0];
            do_reset();
            repeat (3) cyc(w0, h0, 1, 0, dv);
            cyc(w0, h0, 0, (mode != 1), dv);
            cyc(w0, h0, 0, 0, dv);
            if (mode == 2) cyc(w1, h1, 1, 0, dv);
            else begin
              cyc(w0, h0, 1, 0, dv);
              cyc(w1, h1, 1, 0, dv);
            end
            repeat (3) cyc(w1, h1, 1, 0, dv);
            cyc(w1, h1, 0, 1, dv);
            cyc(w1, h1, 1, 0, dv);
            repeat (2) cyc(w1, h1, 1, 0, dv);
          end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule